// File: doc/BRIEF.md
# USB Host Channel Transaction Scheduler

This block decides, on the host side of a USB link, which of six transfer channels issues the next token. Each channel is tied to one device endpoint and one buffer region. A channel is eligible for a token only when its buffer can take, or already holds, a full maximum-size packet. For an IN channel this means free space; for an OUT channel it means queued data. Eligible channels are served in rotating order. The block holds one token outstanding and waits for the device's handshake. A success moves the buffer on by one packet. NAK and error leave the channel to retry. STALL parks the channel until software releases it.

Channel 0 is meant for control transfers and channel 1 for bulk. Channels 2 to 5 are general purpose. All six share the same token logic. The buffer manager reads the commit and consume pulses to move its own counters. The packet engine receives the registered token fields and reports the device's reply on the handshake input.

Top module: `usbh_chan_sched`

## Requirements
- R1: There are six channels. Each has its own endpoint number (4 bits), maximum packet size (11 bits) and direction bit (1 = IN, 0 = OUT). An issued token carries the channel index, that channel's endpoint, its direction and its maximum packet size as the packet length.
- R2: An IN channel is eligible only while its free-space count is at least its maximum packet size. An OUT channel is eligible only while its data count is at least its maximum packet size. A channel whose maximum packet size is 0 is never eligible.
- R3: A channel whose enable bit is low is never given a token, whatever its buffer counts.
- R4: Eligible channels are granted in round-robin order, starting with the channel after the one most recently granted. After reset, channel 0 has first priority.
- R5: Only one token is outstanding. The token valid flag and all token fields stay unchanged from the moment the token is issued until the edge at which the handshake is taken.
- R6: Handshake code 00 means data was received for an IN token or ACK was received for an OUT token. It produces a one-cycle pulse on the issuing channel's bit: on the commit output for IN, or on the consume output for OUT. The pulse appears in the cycle after the handshake is taken, and the token is withdrawn in that same cycle.
- R7: Handshake code 01 (NAK) or 11 (error) produces no pulse. The channel stays eligible, and it is given the same token again on a later grant.
- R8: Handshake code 10 (STALL) produces no pulse and sets that channel's halted flag. A halted channel is not granted until a pulse on its clear input resets the flag. The clear takes effect one cycle after the pulse.
- R9: After a handshake, the token valid flag stays low for at least two cycles before the next token. This lets the buffer counts settle after a commit or consume.
- R10: During and right after reset, the token valid flag, all pulses and all halted flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 6 | Per-channel enable |
| cfg_dir_in | input | 6 | Per-channel direction, 1 = IN |
| cfg_ep | input | 24 | Per-channel endpoint number, 4 bits per channel |
| cfg_mps | input | 66 | Per-channel maximum packet size, 11 bits per channel |
| clr_halt | input | 6 | Per-channel pulse that clears the halted flag |
| buf_free | input | 78 | Per-channel buffer free space, 13 bits per channel |
| buf_fill | input | 78 | Per-channel buffered data count, 13 bits per channel |
| hs_valid | input | 1 | Handshake result is present |
| hs_code | input | 2 | 00 success, 01 NAK, 10 STALL, 11 error |
| tok_valid | output | 1 | A token is outstanding |
| tok_ch | output | 3 | Channel index of the token |
| tok_ep | output | 4 | Endpoint number of the token |
| tok_in | output | 1 | Token direction, 1 = IN |
| tok_len | output | 11 | Packet length (maximum packet size) |
| commit_pulse | output | 6 | IN data committed to the buffer of this channel |
| consume_pulse | output | 6 | OUT data consumed from the buffer of this channel |
| halted | output | 6 | Per-channel STALL flag |

## Verification
The assertions check, on every cycle, the properties that hold from one cycle to the next:
- no token starts on a disabled or halted channel;
- the fields of a token hold steady while it is outstanding;
- pulses follow only a successful handshake of the matching direction, and at most one pulse is active at a time;
- a halted flag rises only after a STALL;
- a gap of two idle cycles follows each handshake.

Some behaviour can be shown only by the bench's scenarios:
- the grant order across channels;
- the exact threshold at which a buffer count makes a channel eligible;
- that the same packet is retried after NAK or error;
- that release from a halt comes only through the clear input.

The bench sweeps every channel, both directions and every handshake code.

// File: rtl/usbh_sched_pkg.sv
package usbh_sched_pkg;

  typedef enum logic [1:0] {
    HS_OK    = 2'b00,
    HS_NAK   = 2'b01,
    HS_STALL = 2'b10,
    HS_ERR   = 2'b11
  } hs_code_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_WAIT = 2'b01,
    ST_GAP  = 2'b10
  } sched_state_e;

endpackage

// File: rtl/usbh_ch_elig.sv
module usbh_ch_elig #(
  parameter int NCH  = 6,
  parameter int MPSW = 11,
  parameter int CNTW = 13
) (
  input  logic [NCH-1:0]      en,
  input  logic [NCH-1:0]      dir_in,
  input  logic [NCH-1:0]      halted,
  input  logic [NCH*MPSW-1:0] mps,
  input  logic [NCH*CNTW-1:0] free_cnt,
  input  logic [NCH*CNTW-1:0] fill_cnt,
  output logic [NCH-1:0]      req
);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [CNTW-1:0] mps_ext;
    logic [CNTW-1:0] room;
    logic [CNTW-1:0] data;
    logic            enough;

    assign mps_ext = CNTW'(mps[g*MPSW +: MPSW]);
    assign room    = free_cnt[g*CNTW +: CNTW];
    assign data    = fill_cnt[g*CNTW +: CNTW];
    assign enough  = dir_in[g] ? (room >= mps_ext) : (data >= mps_ext);
    assign req[g]  = en[g] & ~halted[g] & (mps_ext != '0) & enough;
  end

endmodule

// File: rtl/usbh_rr_pick.sv
module usbh_rr_pick #(
  parameter int NCH = 6,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] req,
  input  logic [CHW-1:0] last,
  output logic           pick_vld,
  output logic [CHW-1:0] pick_idx
);

  always_comb begin
    int cand;
    pick_vld = 1'b0;
    pick_idx = '0;
    cand     = 0;
    for (int k = 0; k < NCH; k++) begin
      cand = (int'(last) + 1 + k) % NCH;
      if (!pick_vld && req[cand]) begin
        pick_vld = 1'b1;
        pick_idx = cand[CHW-1:0];
      end
    end
  end

endmodule

// File: rtl/usbh_halt_flags.sv
module usbh_halt_flags #(
  parameter int NCH = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] set_vec,
  input  logic [NCH-1:0] clr_vec,
  output logic [NCH-1:0] halted
);

  always_ff @(posedge clk) begin
    if (rst) begin
      halted <= '0;
    end else begin
      halted <= (halted & ~clr_vec) | set_vec;
    end
  end

endmodule

// File: rtl/usbh_chan_sched.sv
module usbh_chan_sched
  import usbh_sched_pkg::*;
#(
  parameter int NCH  = 6,
  parameter int EPW  = 4,
  parameter int MPSW = 11,
  parameter int CNTW = 13,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NCH-1:0]      cfg_en,
  input  logic [NCH-1:0]      cfg_dir_in,
  input  logic [NCH*EPW-1:0]  cfg_ep,
  input  logic [NCH*MPSW-1:0] cfg_mps,
  input  logic [NCH-1:0]      clr_halt,
  input  logic [NCH*CNTW-1:0] buf_free,
  input  logic [NCH*CNTW-1:0] buf_fill,
  input  logic                hs_valid,
  input  logic [1:0]          hs_code,
  output logic                tok_valid,
  output logic [CHW-1:0]      tok_ch,
  output logic [EPW-1:0]      tok_ep,
  output logic                tok_in,
  output logic [MPSW-1:0]     tok_len,
  output logic [NCH-1:0]      commit_pulse,
  output logic [NCH-1:0]      consume_pulse,
  output logic [NCH-1:0]      halted
);

  sched_state_e   state;
  logic [CHW-1:0] last_ch;
  logic [NCH-1:0] req;
  logic           pick_vld;
  logic [CHW-1:0] pick_idx;
  logic [NCH-1:0] stall_set;
  hs_code_e       code;
  logic           hs_take;

  assign code    = hs_code_e'(hs_code);
  assign hs_take = (state == ST_WAIT) && hs_valid;

  usbh_ch_elig #(.NCH(NCH), .MPSW(MPSW), .CNTW(CNTW)) i_elig (
    .en       (cfg_en),
    .dir_in   (cfg_dir_in),
    .halted   (halted),
    .mps      (cfg_mps),
    .free_cnt (buf_free),
    .fill_cnt (buf_fill),
    .req      (req)
  );

  usbh_rr_pick #(.NCH(NCH)) i_pick (
    .req      (req),
    .last     (last_ch),
    .pick_vld (pick_vld),
    .pick_idx (pick_idx)
  );

  always_comb begin
    stall_set = '0;
    if (hs_take && code == HS_STALL) stall_set[tok_ch] = 1'b1;
  end

  usbh_halt_flags #(.NCH(NCH)) i_halt (
    .clk     (clk),
    .rst     (rst),
    .set_vec (stall_set),
    .clr_vec (clr_halt),
    .halted  (halted)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      last_ch       <= CHW'(NCH - 1);
      tok_valid     <= 1'b0;
      tok_ch        <= '0;
      tok_ep        <= '0;
      tok_in        <= 1'b0;
      tok_len       <= '0;
      commit_pulse  <= '0;
      consume_pulse <= '0;
    end else begin
      commit_pulse  <= '0;
      consume_pulse <= '0;
      case (state)
        ST_IDLE: begin
          if (pick_vld) begin
            tok_valid <= 1'b1;
            tok_ch    <= pick_idx;
            tok_ep    <= cfg_ep[pick_idx*EPW +: EPW];
            tok_in    <= cfg_dir_in[pick_idx];
            tok_len   <= cfg_mps[pick_idx*MPSW +: MPSW];
            last_ch   <= pick_idx;
            state     <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (hs_valid) begin
            tok_valid <= 1'b0;
            state     <= ST_GAP;
            if (code == HS_OK) begin
              if (tok_in) commit_pulse[tok_ch]  <= 1'b1;
              else        consume_pulse[tok_ch] <= 1'b1;
            end
          end
        end
        default: begin
          state <= ST_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/usbh_chan_sched_chk.sv
module usbh_chan_sched_chk #(
  parameter int NCH  = 6,
  parameter int MPSW = 11,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic            clk,
  input logic            rst,
  input logic [NCH-1:0]  cfg_en,
  input logic            hs_valid,
  input logic [1:0]      hs_code,
  input logic            tok_valid,
  input logic [CHW-1:0]  tok_ch,
  input logic            tok_in,
  input logic [MPSW-1:0] tok_len,
  input logic [NCH-1:0]  commit_pulse,
  input logic [NCH-1:0]  consume_pulse,
  input logic [NCH-1:0]  halted
);

  logic [NCH-1:0] en_q;
  logic [NCH-1:0] halt_q;

  always_ff @(posedge clk) begin
    en_q   <= cfg_en;
    halt_q <= halted;
  end

  // R3
  grant_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tok_valid) |-> en_q[tok_ch]);

  // R8
  grant_not_halted_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tok_valid) |-> !halt_q[tok_ch]);

  // R5
  token_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && $past(tok_valid)) |-> ($stable(tok_ch) && $stable(tok_len) && $stable(tok_in)));

  // R6
  commit_src_chk: assert property (@(posedge clk) disable iff (rst)
    (commit_pulse != '0) |-> $past(hs_valid && tok_valid && tok_in && hs_code == 2'b00));

  // R6
  consume_src_chk: assert property (@(posedge clk) disable iff (rst)
    (consume_pulse != '0) |-> $past(hs_valid && tok_valid && !tok_in && hs_code == 2'b00));

  // R6
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({commit_pulse, consume_pulse}));

  // R8
  halt_source_chk: assert property (@(posedge clk) disable iff (rst)
    ((halted & ~$past(halted)) != '0) |-> $past(hs_valid && tok_valid && hs_code == 2'b10));

  // R9
  token_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(tok_valid) |=> !tok_valid);

endmodule

bind usbh_chan_sched usbh_chan_sched_chk #(.NCH(NCH), .MPSW(MPSW)) i_chk (
  .clk           (clk),
  .rst           (rst),
  .cfg_en        (cfg_en),
  .hs_valid      (hs_valid),
  .hs_code       (hs_code),
  .tok_valid     (tok_valid),
  .tok_ch        (tok_ch),
  .tok_in        (tok_in),
  .tok_len       (tok_len),
  .commit_pulse  (commit_pulse),
  .consume_pulse (consume_pulse),
  .halted        (halted)
);

// File: tb/test_usbh_chan_sched.sv
`timescale 1ns/1ps
module test_usbh_chan_sched;
  localparam int NCH = 6, EPW = 4, MPSW = 11, CNTW = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0]      cfg_en = '0, cfg_dir_in = '0, clr_halt = '0;
  logic [NCH*EPW-1:0]  cfg_ep = '0;
  logic [NCH*MPSW-1:0] cfg_mps = '0;
  logic [NCH*CNTW-1:0] buf_free = '0, buf_fill = '0;
  logic                hs_valid = 1'b0;
  logic [1:0]          hs_code = 2'b00;
  logic                tok_valid, tok_in;
  logic [2:0]          tok_ch;
  logic [EPW-1:0]      tok_ep;
  logic [MPSW-1:0]     tok_len;
  logic [NCH-1:0]      commit_pulse, consume_pulse, halted;

  int vectors = 0, miscompares = 0;
  int ep_m[NCH], mps_m[NCH], free_m[NCH], fill_m[NCH];
  bit dir_m[NCH], en_m[NCH];

  always #4 clk = ~clk;

  usbh_chan_sched i_usbh_chan_sched (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_dir_in(cfg_dir_in),
    .cfg_ep(cfg_ep), .cfg_mps(cfg_mps), .clr_halt(clr_halt),
    .buf_free(buf_free), .buf_fill(buf_fill), .hs_valid(hs_valid),
    .hs_code(hs_code), .tok_valid(tok_valid), .tok_ch(tok_ch),
    .tok_ep(tok_ep), .tok_in(tok_in), .tok_len(tok_len),
    .commit_pulse(commit_pulse), .consume_pulse(consume_pulse),
    .halted(halted)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic apply();
    for (int c = 0; c < NCH; c++) begin
      cfg_en[c]     = en_m[c];
      cfg_dir_in[c] = dir_m[c];
      cfg_ep[c*EPW +: EPW]     = EPW'(ep_m[c]);
      cfg_mps[c*MPSW +: MPSW]  = MPSW'(mps_m[c]);
      buf_free[c*CNTW +: CNTW] = CNTW'(free_m[c]);
      buf_fill[c*CNTW +: CNTW] = CNTW'(fill_m[c]);
    end
  endtask

  task automatic clear_model();
    for (int c = 0; c < NCH; c++) begin
      en_m[c] = 0; dir_m[c] = 0; ep_m[c] = 0; mps_m[c] = 0; free_m[c] = 0; fill_m[c] = 0;
    end
    apply();
  endtask

  task automatic quiet(input int n, input string req);
    bit seen = 0;
    repeat (n) begin
      @(negedge clk);
      if (tok_valid) seen = 1;
    end
    chk(req, "no token while ineligible", seen, 0);
  endtask

  task automatic serve(input int ch, input int code, input string req);
    int t = 0;
    longint exp_commit, exp_consume;
    while (!tok_valid && t < 60) begin
      @(negedge clk);
      t++;
    end
    chk(req, "token issued", tok_valid, 1);
    if (!tok_valid) return;
    chk(req, "grant channel (R4)", tok_ch, ch);
    chk("R1", "token endpoint", tok_ep, ep_m[ch]);
    chk("R1", "token direction", tok_in, dir_m[ch]);
    chk("R1", "token length", tok_len, mps_m[ch]);
    @(negedge clk);
    chk("R5", "token held", {tok_valid, tok_ch}, {1'b1, 3'(ch)});
    hs_valid = 1'b1;
    hs_code  = 2'(code);
    @(negedge clk);
    hs_valid = 1'b0;
    exp_commit  = (code == 0 &&  dir_m[ch]) ? (64'd1 << ch) : 0;
    exp_consume = (code == 0 && !dir_m[ch]) ? (64'd1 << ch) : 0;
    chk(code == 0 ? "R6" : (code == 2 ? "R8" : "R7"), "commit pulse", commit_pulse, exp_commit);
    chk(code == 0 ? "R6" : (code == 2 ? "R8" : "R7"), "consume pulse", consume_pulse, exp_consume);
    chk("R8", "halted flag", halted[ch], code == 2);
    chk("R6", "token withdrawn", tok_valid, 0);
    if (code == 0) begin
      if (dir_m[ch]) free_m[ch] -= mps_m[ch];
      else           fill_m[ch] -= mps_m[ch];
      apply();
    end
    @(negedge clk);
    chk("R9", "idle gap after handshake", tok_valid, 0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R10", "tok_valid after reset", tok_valid, 0);
    chk("R10", "pulses after reset", {commit_pulse, consume_pulse}, 0);
    chk("R10", "halted after reset", halted, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    clear_model();
    do_reset();

    // R6 R7 R8 R2: sweep every channel, direction and handshake code
    for (int ch = 0; ch < NCH; ch++) begin
      for (int d = 0; d < 2; d++) begin
        for (int code = 0; code < 4; code++) begin
          clear_model();
          en_m[ch] = 1; dir_m[ch] = d[0];
          ep_m[ch] = (ch * 5 + d + code) % 16;
          mps_m[ch] = 8 * (ch + 1) + 4 * d + code + 1;
          if (d == 1) free_m[ch] = mps_m[ch]; else fill_m[ch] = mps_m[ch];
          apply();
          serve(ch, code, "R6");
          if (code == 1 || code == 3) begin
            serve(ch, 0, "R7");
          end else if (code == 2) begin
            quiet(20, "R8");
            @(negedge clk); clr_halt = 6'(1 << ch);
            @(negedge clk); clr_halt = '0;
            chk("R8", "halt cleared", halted[ch], 0);
            serve(ch, 0, "R8");
          end
          quiet(12, "R2");
        end
      end
    end

    // R2 thresholds
    clear_model();
    en_m[3] = 1; mps_m[3] = 20; fill_m[3] = 19; ep_m[3] = 7; apply();
    quiet(20, "R2");
    fill_m[3] = 20; apply();
    serve(3, 0, "R2");
    clear_model();
    en_m[2] = 1; dir_m[2] = 1; mps_m[2] = 16; free_m[2] = 15; ep_m[2] = 9; apply();
    quiet(20, "R2");
    free_m[2] = 16; apply();
    serve(2, 0, "R2");
    clear_model();
    en_m[1] = 1; mps_m[1] = 0; fill_m[1] = 100; apply();
    quiet(20, "R2");

    // R3 disabled channel
    clear_model();
    mps_m[4] = 8; fill_m[4] = 400; ep_m[4] = 4; apply();
    quiet(20, "R3");
    en_m[4] = 1; apply();
    serve(4, 0, "R3");
    clear_model();

    // R4 round robin after reset
    for (int c = 0; c < NCH; c++) begin
      en_m[c] = 1; mps_m[c] = 4; fill_m[c] = 400; ep_m[c] = 15 - c;
    end
    apply();
    do_reset();
    for (int k = 0; k < 12; k++) serve(k % NCH, 0, "R4");
    en_m[0] = 0; en_m[2] = 0; en_m[4] = 0; apply();
    serve(1, 0, "R4");
    serve(3, 0, "R4");
    serve(5, 1, "R7");
    serve(1, 3, "R7");
    serve(3, 0, "R4");
    serve(5, 0, "R7");

    // R10 reset clears halt
    serve(1, 2, "R8");
    do_reset();
    clear_model();
    quiet(4, "R10");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule